// File: doc/BRIEF.md
# Serial audio-link output frame slot splitter

This block sits on the receive side of a codec that is fed by a serial audio link. It runs on the link's bit clock. It samples the frame sync and the serial data line and cuts each 256-bit output frame into its slots. The first slot is a 16-bit tag word that carries three things: a frame-valid flag, one valid flag for each of the twelve following slots, and a two-bit codec identifier.

The decoded tag fields are held on the outputs until the next tag arrives. The command address and command data slots are passed to a register-access interface as one strobed command, but only when the frame is valid, the address slot is flagged and the identifier matches this device. The general-purpose slot is passed out with its own strobe.

A selector picks one of four fixed slot pairs as the left and right sources for a stereo DAC. One sample pair is issued with a strobe per frame, and only when the tag marks the frame and both slots of the pair as valid. A lower sample rate is carried by leaving the pair's flags clear in the frames that hold no sample. A sync edge that arrives inside a frame is reported, and the block restarts on it.

Top module: `aclink_out_demux`

## Requirements
- R1: A frame begins on the rising clock edge where `sync_i` is sampled high after it was sampled low. That edge samples the tag's most significant bit. The frame is a 16-bit tag followed by twelve 20-bit slots, each sent most significant bit first, for 256 bits in all. `sdata_i` has no effect outside a frame.
- R2: Number the edge that samples a frame's first bit as edge 0. The result for slot n (the tag being n = 0) is visible right after edge 16+20n. `tag_strobe` pulses for one cycle after edge 16.
- R3: The tag fields are decoded as follows. `tag_frame_valid` is tag bit 15. `tag_slot_valid[i]` is tag bit 14−i, which is the flag for slot i+1. `tag_codec_id` is tag bits 1:0. Tag bit 2 has no effect.
- R4: `cmd_strobe` pulses after slot 2 when all three of these hold: the frame-valid flag is set, the slot 1 flag is set, and the codec ID equals `MY_ID` (default 0). `cmd_addr` then carries slot 1, `cmd_data` carries slot 2, and `cmd_data_ok` carries the slot 2 flag.
- R5: A frame whose codec ID differs from `MY_ID` produces no `cmd_strobe`.
- R6: `dac_pair_sel` picks the left/right source slots: 0 selects 3/4, 1 selects 6/9, 2 selects 7/8 and 3 selects 10/11. The samples are passed through unmodified on `dac_left` and `dac_right`.
- R7: `dac_strobe` pulses once per frame, after the right-hand slot of the pair. It pulses only if the frame-valid flag and both of the pair's slot flags are set.
- R8: When the frame-valid flag is clear, no `cmd_strobe`, `gpio_strobe` or `dac_strobe` is issued for that frame.
- R9: `gpio_strobe` pulses after slot 12 with `gpio_word` equal to slot 12 when the frame-valid flag and the slot 12 flag are set. The codec ID does not affect it.
- R10: A sync rise while a frame is in progress pulses `sync_err` for one cycle and starts a new frame on that edge. The unfinished frame produces no further strobes.
- R11: After a synchronous reset, every strobe is low and every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync; its rising edge starts a frame |
| sdata_i | input | 1 | Serial output-frame data |
| dac_pair_sel | input | 2 | DAC source pair selector |
| tag_strobe | output | 1 | One-cycle pulse when a new tag is decoded |
| tag_frame_valid | output | 1 | Frame-valid flag of the last tag |
| tag_slot_valid | output | 12 | Per-slot valid flags; bit i is slot i+1 |
| tag_codec_id | output | 2 | Codec identifier of the last tag |
| cmd_strobe | output | 1 | Accepted command pulse |
| cmd_addr | output | 20 | Command address slot word |
| cmd_data | output | 20 | Command data slot word |
| cmd_data_ok | output | 1 | Slot 2 flag of the accepted command |
| gpio_strobe | output | 1 | General-purpose slot pulse |
| gpio_word | output | 20 | General-purpose slot word |
| dac_strobe | output | 1 | Stereo sample pulse |
| dac_left | output | 20 | Left DAC sample |
| dac_right | output | 20 | Right DAC sample |
| sync_err | output | 1 | Sync rise seen inside a frame |

## Verification
The assertions assume three things about the inputs. First, `dac_pair_sel` is stable from the left slot of a frame until its strobe. Second, `sync_i` is low for at least one clock before each rise. Third, reset is held for several edges. The stimulus changes the selector only between frames, on the falling clock edge, with the line idle. It drops sync after the tag bits and keeps it low until the next frame. The misplaced-sync case comes after the tag, so the sync line is already low when the early rise arrives.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int DATA_SLOTS = 12;

  function automatic int pair_left(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3;
      2'd1:    return 6;
      2'd2:    return 7;
      default: return 10;
    endcase
  endfunction

  function automatic int pair_right(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 9;
      2'd2:    return 8;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/aclink_framer.sv
module aclink_framer #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  localparam int IDX_W  = $clog2(N_SLOTS + 1),
  localparam int BIT_W  = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic              slot_done_o,
  output logic [IDX_W-1:0]  slot_num_o,
  output logic [SLOT_W-1:0] slot_word_o,
  output logic              sync_err_o
);
  logic              sync_q, in_frame;
  logic [IDX_W-1:0]  idx;
  logic [BIT_W-1:0]  bit_cnt, last_bit;
  logic [SLOT_W-1:0] sh, sh_nx;
  logic              start;

  assign start    = sync_i & ~sync_q;
  assign sh_nx    = {sh[SLOT_W-2:0], sdata_i};
  assign last_bit = (idx == '0) ? BIT_W'(TAG_W - 1) : BIT_W'(SLOT_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= 1'b0;
      in_frame    <= 1'b0;
      idx         <= '0;
      bit_cnt     <= '0;
      sh          <= '0;
      slot_done_o <= 1'b0;
      slot_num_o  <= '0;
      slot_word_o <= '0;
      sync_err_o  <= 1'b0;
    end else begin
      sync_q      <= sync_i;
      slot_done_o <= 1'b0;
      sync_err_o  <= 1'b0;
      if (start) begin
        sync_err_o <= in_frame;
        in_frame   <= 1'b1;
        idx        <= '0;
        bit_cnt    <= BIT_W'(1);
        sh         <= {{(SLOT_W-1){1'b0}}, sdata_i};
      end else if (in_frame) begin
        sh <= sh_nx;
        if (bit_cnt == last_bit) begin
          slot_done_o <= 1'b1;
          slot_num_o  <= idx;
          slot_word_o <= sh_nx;
          bit_cnt     <= '0;
          if (idx == IDX_W'(N_SLOTS)) in_frame <= 1'b0;
          else                        idx      <= idx + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R1: slot numbers never run past the last data slot
  a_r1_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot_done_o |-> (slot_num_o <= IDX_W'(N_SLOTS)));
  // R10: a misplaced sync is reported as a single-cycle pulse
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    sync_err_o |=> !sync_err_o);
endmodule

// File: rtl/aclink_tag_dec.sv
module aclink_tag_dec #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int ID_W    = 2,
  localparam int IDX_W  = $clog2(N_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_done_i,
  input  logic [IDX_W-1:0]   slot_num_i,
  input  logic [SLOT_W-1:0]  slot_word_i,
  output logic               tag_strobe_o,
  output logic               frame_valid_o,
  output logic [N_SLOTS-1:0] slot_valid_o,
  output logic [ID_W-1:0]    codec_id_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_strobe_o  <= 1'b0;
      frame_valid_o <= 1'b0;
      slot_valid_o  <= '0;
      codec_id_o    <= '0;
    end else begin
      tag_strobe_o <= 1'b0;
      if (slot_done_i && slot_num_i == '0) begin
        tag_strobe_o  <= 1'b1;
        frame_valid_o <= slot_word_i[TAG_W-1];
        for (int i = 0; i < N_SLOTS; i++)
          slot_valid_o[i] <= slot_word_i[TAG_W-2-i];
        codec_id_o    <= slot_word_i[ID_W-1:0];
      end
    end
  end

  // R2: at most one tag per frame, so the strobe never lasts two cycles
  a_r2_tag_pulse: assert property (@(posedge clk) disable iff (rst)
    tag_strobe_o |=> !tag_strobe_o);
endmodule

// File: rtl/aclink_ctrl_slots.sv
module aclink_ctrl_slots #(
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int ID_W    = 2,
  parameter int MY_ID   = 0,
  localparam int IDX_W  = $clog2(N_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_done_i,
  input  logic [IDX_W-1:0]   slot_num_i,
  input  logic [SLOT_W-1:0]  slot_word_i,
  input  logic               frame_valid_i,
  input  logic [N_SLOTS-1:0] slot_valid_i,
  input  logic [ID_W-1:0]    codec_id_i,
  output logic               cmd_strobe_o,
  output logic [SLOT_W-1:0]  cmd_addr_o,
  output logic [SLOT_W-1:0]  cmd_data_o,
  output logic               cmd_data_ok_o,
  output logic               gpio_strobe_o,
  output logic [SLOT_W-1:0]  gpio_word_o
);
  logic [SLOT_W-1:0] addr_q;
  logic              accept;

  assign accept = frame_valid_i && slot_valid_i[0] && (codec_id_i == ID_W'(MY_ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q        <= '0;
      cmd_strobe_o  <= 1'b0;
      cmd_addr_o    <= '0;
      cmd_data_o    <= '0;
      cmd_data_ok_o <= 1'b0;
      gpio_strobe_o <= 1'b0;
      gpio_word_o   <= '0;
    end else begin
      cmd_strobe_o  <= 1'b0;
      gpio_strobe_o <= 1'b0;
      if (slot_done_i && slot_num_i == IDX_W'(1)) addr_q <= slot_word_i;
      if (slot_done_i && slot_num_i == IDX_W'(2) && accept) begin
        cmd_strobe_o  <= 1'b1;
        cmd_addr_o    <= addr_q;
        cmd_data_o    <= slot_word_i;
        cmd_data_ok_o <= slot_valid_i[1];
      end
      if (slot_done_i && slot_num_i == IDX_W'(N_SLOTS)
          && frame_valid_i && slot_valid_i[N_SLOTS-1]) begin
        gpio_strobe_o <= 1'b1;
        gpio_word_o   <= slot_word_i;
      end
    end
  end

  // R5: commands only reach the register side for this device's ID
  a_r5_id_match: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe_o |-> (codec_id_i == ID_W'(MY_ID)));
  // R8: nothing is issued from a frame marked invalid
  a_r8_needs_frame: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe_o || gpio_strobe_o) |-> frame_valid_i);
endmodule

// File: rtl/aclink_dac_route.sv
module aclink_dac_route
  import aclink_pkg::*;
#(
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  localparam int IDX_W  = $clog2(N_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         pair_sel_i,
  input  logic               slot_done_i,
  input  logic [IDX_W-1:0]   slot_num_i,
  input  logic [SLOT_W-1:0]  slot_word_i,
  input  logic               frame_valid_i,
  input  logic [N_SLOTS-1:0] slot_valid_i,
  output logic               dac_strobe_o,
  output logic [SLOT_W-1:0]  dac_left_o,
  output logic [SLOT_W-1:0]  dac_right_o
);
  logic [IDX_W-1:0]  l_num, r_num;
  logic [SLOT_W-1:0] left_q;
  logic              left_seen;
  logic              l_ok, r_ok;

  assign l_num = IDX_W'(pair_left(pair_sel_i));
  assign r_num = IDX_W'(pair_right(pair_sel_i));
  assign l_ok  = slot_valid_i[l_num - IDX_W'(1)];
  assign r_ok  = slot_valid_i[r_num - IDX_W'(1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q       <= '0;
      left_seen    <= 1'b0;
      dac_strobe_o <= 1'b0;
      dac_left_o   <= '0;
      dac_right_o  <= '0;
    end else begin
      dac_strobe_o <= 1'b0;
      if (slot_done_i) begin
        if (slot_num_i == '0) left_seen <= 1'b0;
        if (slot_num_i == l_num) begin
          left_q    <= slot_word_i;
          left_seen <= 1'b1;
        end
        if (slot_num_i == r_num && left_seen && frame_valid_i && l_ok && r_ok) begin
          dac_strobe_o <= 1'b1;
          dac_left_o   <= left_q;
          dac_right_o  <= slot_word_i;
        end
      end
    end
  end

  // R7: a sample pair leaves only when the tag flags frame and both slots
  a_r7_pair_valid: assert property (@(posedge clk) disable iff (rst)
    dac_strobe_o |-> (frame_valid_i && l_ok && r_ok));
  // R7: at most one sample pair per frame
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    dac_strobe_o |=> !dac_strobe_o);
endmodule

// File: rtl/aclink_out_demux.sv
module aclink_out_demux
  import aclink_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = DATA_SLOTS,
  parameter int ID_W    = 2,
  parameter int MY_ID   = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_i,
  input  logic               sdata_i,
  input  logic [1:0]         dac_pair_sel,
  output logic               tag_strobe,
  output logic               tag_frame_valid,
  output logic [N_SLOTS-1:0] tag_slot_valid,
  output logic [ID_W-1:0]    tag_codec_id,
  output logic               cmd_strobe,
  output logic [SLOT_W-1:0]  cmd_addr,
  output logic [SLOT_W-1:0]  cmd_data,
  output logic               cmd_data_ok,
  output logic               gpio_strobe,
  output logic [SLOT_W-1:0]  gpio_word,
  output logic               dac_strobe,
  output logic [SLOT_W-1:0]  dac_left,
  output logic [SLOT_W-1:0]  dac_right,
  output logic               sync_err
);
  localparam int IDX_W = $clog2(N_SLOTS + 1);

  logic              s_done;
  logic [IDX_W-1:0]  s_num;
  logic [SLOT_W-1:0] s_word;

  aclink_framer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_framer (
    .clk(clk), .rst(rst), .sync_i(sync_i), .sdata_i(sdata_i),
    .slot_done_o(s_done), .slot_num_o(s_num), .slot_word_o(s_word),
    .sync_err_o(sync_err));

  aclink_tag_dec #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_tag (
    .clk(clk), .rst(rst), .slot_done_i(s_done), .slot_num_i(s_num), .slot_word_i(s_word),
    .tag_strobe_o(tag_strobe), .frame_valid_o(tag_frame_valid),
    .slot_valid_o(tag_slot_valid), .codec_id_o(tag_codec_id));

  aclink_ctrl_slots #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .ID_W(ID_W), .MY_ID(MY_ID)) u_ctrl (
    .clk(clk), .rst(rst), .slot_done_i(s_done), .slot_num_i(s_num), .slot_word_i(s_word),
    .frame_valid_i(tag_frame_valid), .slot_valid_i(tag_slot_valid), .codec_id_i(tag_codec_id),
    .cmd_strobe_o(cmd_strobe), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .cmd_data_ok_o(cmd_data_ok), .gpio_strobe_o(gpio_strobe), .gpio_word_o(gpio_word));

  aclink_dac_route #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_dac (
    .clk(clk), .rst(rst), .pair_sel_i(dac_pair_sel),
    .slot_done_i(s_done), .slot_num_i(s_num), .slot_word_i(s_word),
    .frame_valid_i(tag_frame_valid), .slot_valid_i(tag_slot_valid),
    .dac_strobe_o(dac_strobe), .dac_left_o(dac_left), .dac_right_o(dac_right));

  // R2: each strobe belongs to a different slot, so no two coincide
  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tag_strobe, cmd_strobe, gpio_strobe, dac_strobe}));
endmodule

// File: tb/tb_aclink_out_demux.sv
module tb_aclink_out_demux;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_i = 1'b0, sdata_i = 1'b0;
  logic [1:0] dac_pair_sel = 2'd0;
  logic tag_strobe, tag_frame_valid, cmd_strobe, cmd_data_ok, gpio_strobe, dac_strobe, sync_err;
  logic [11:0] tag_slot_valid;
  logic [1:0]  tag_codec_id;
  logic [19:0] cmd_addr, cmd_data, gpio_word, dac_left, dac_right;

  always #2 clk = ~clk;

  aclink_out_demux dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .sdata_i(sdata_i), .dac_pair_sel(dac_pair_sel),
    .tag_strobe(tag_strobe), .tag_frame_valid(tag_frame_valid), .tag_slot_valid(tag_slot_valid),
    .tag_codec_id(tag_codec_id), .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_data_ok(cmd_data_ok), .gpio_strobe(gpio_strobe),
    .gpio_word(gpio_word), .dac_strobe(dac_strobe), .dac_left(dac_left),
    .dac_right(dac_right), .sync_err(sync_err));

  int nchk = 0, nfail = 0;
  int cyc = 0, start_cyc = 0;
  int n_tag = 0, n_cmd = 0, n_gpio = 0, n_dac = 0, n_err = 0;
  int tag_cyc = 0, dac_cyc = 0;
  logic [19:0] m_ca, m_cd, m_gw, m_dl, m_dr;
  logic m_cok;
  logic [19:0] slots [1:12];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (!rst) begin
    if (tag_strobe) begin n_tag++; tag_cyc = cyc; end
    if (cmd_strobe) begin n_cmd++; m_ca = cmd_addr; m_cd = cmd_data; m_cok = cmd_data_ok; end
    if (gpio_strobe) begin n_gpio++; m_gw = gpio_word; end
    if (dac_strobe) begin n_dac++; dac_cyc = cyc; m_dl = dac_left; m_dr = dac_right; end
    if (sync_err) n_err++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill_slots();
    for (int n = 1; n <= 12; n++) slots[n] = {4'(n), 16'(16'hC300 + n)};
  endtask

  task automatic send_frame(input logic [15:0] tag, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i == 0) start_cyc = cyc + 1;
      sync_i = (i < 16);
      if (i < 16) sdata_i = tag[15-i];
      else sdata_i = slots[(i-16)/20 + 1][19 - ((i-16)%20)];
    end
    @(negedge clk);
    sync_i = 1'b0; sdata_i = 1'b0;
  endtask

  function automatic int lslot(input logic [1:0] s);
    return (s == 0) ? 3 : (s == 1) ? 6 : (s == 2) ? 7 : 10;
  endfunction
  function automatic int rslot(input logic [1:0] s);
    return (s == 0) ? 4 : (s == 1) ? 9 : (s == 2) ? 8 : 11;
  endfunction

  // {sel[1:0], tag[15:0], left[19:0], right[19:0], expect_strobe}
  localparam logic [58:0] VEC [8] = '{
    {2'd0, 16'hFFF8, 20'hABCDE, 20'h12345, 1'b1},
    {2'd1, 16'h8240, 20'h80001, 20'h7FFFE, 1'b1},
    {2'd2, 16'h8180, 20'h00000, 20'hFFFFF, 1'b1},
    {2'd3, 16'h8034, 20'h5A5A5, 20'hA5A5A, 1'b1},
    {2'd0, 16'h7FF8, 20'h11111, 20'h22222, 1'b0},
    {2'd0, 16'h9000, 20'h33333, 20'h44444, 1'b0},
    {2'd1, 16'h8200, 20'h55555, 20'h66666, 1'b0},
    {2'd2, 16'h8080, 20'h77777, 20'h88888, 1'b0}
  };

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int d0, c0, g0, t0, e0;
    logic [11:0] expv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk({tag_strobe, cmd_strobe, gpio_strobe, dac_strobe, sync_err} == 0, "R11", "strobes", 0, 0);
    chk({tag_frame_valid, tag_slot_valid, tag_codec_id, cmd_addr, cmd_data, cmd_data_ok,
         gpio_word, dac_left, dac_right} == 0, "R11", "data", 32'(dac_left), 0);

    // R6 R7: table of pair selections and tag patterns
    for (int v = 0; v < 8; v++) begin
      logic [1:0] sel; logic [15:0] tg; logic [19:0] lv, rv; logic ex;
      {sel, tg, lv, rv, ex} = VEC[v];
      fill_slots();
      slots[lslot(sel)] = lv;
      slots[rslot(sel)] = rv;
      dac_pair_sel = sel;
      d0 = n_dac;
      send_frame(tg, 256);
      repeat (4) @(negedge clk);
      chk(n_dac - d0 == int'(ex), "R7", "strobe count", 32'(n_dac - d0), 32'(ex));
      if (ex) begin
        chk(m_dl == lv, "R6", "left sample", 32'(m_dl), 32'(lv));
        chk(m_dr == rv, "R6", "right sample", 32'(m_dr), 32'(rv));
        // R2: result of right slot n visible after edge 16+20n
        chk(dac_cyc - start_cyc == 16 + 20 * rslot(sel), "R2", "dac timing",
            32'(dac_cyc - start_cyc), 32'(16 + 20 * rslot(sel)));
      end
      chk(tag_cyc - start_cyc == 16, "R2", "tag timing", 32'(tag_cyc - start_cyc), 16);
    end

    // R3: tag field decode, bit 2 set and must be ignored
    fill_slots();
    send_frame(16'h5556, 256);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 12; i++) expv[i] = 1'(16'h5556 >> (14 - i));
    chk(tag_frame_valid == 1'b0, "R3", "frame valid", 32'(tag_frame_valid), 0);
    chk(tag_slot_valid == expv, "R3", "slot flags", 32'(tag_slot_valid), 32'(expv));
    chk(tag_codec_id == 2'd2, "R3", "codec id", 32'(tag_codec_id), 2);

    // R4 R9: accepted command and general-purpose slot
    slots[1] = 20'h87C00; slots[2] = 20'h12345; slots[12] = 20'hF0F0F;
    c0 = n_cmd; g0 = n_gpio;
    send_frame(16'hE008, 256);
    repeat (4) @(negedge clk);
    chk(n_cmd - c0 == 1, "R4", "cmd count", 32'(n_cmd - c0), 1);
    chk(m_ca == 20'h87C00, "R4", "cmd addr", 32'(m_ca), 32'h87C00);
    chk(m_cd == 20'h12345, "R4", "cmd data", 32'(m_cd), 32'h12345);
    chk(m_cok == 1'b1, "R4", "data ok", 32'(m_cok), 1);
    chk(n_gpio - g0 == 1 && m_gw == 20'hF0F0F, "R9", "gpio word", 32'(m_gw), 32'hF0F0F);

    // R4: data flag clear still carries a command with data_ok low
    c0 = n_cmd;
    send_frame(16'hC000, 256);
    repeat (4) @(negedge clk);
    chk(n_cmd - c0 == 1 && m_cok == 1'b0, "R4", "data ok low", 32'(m_cok), 0);

    // R5: other codec ID, no command; gpio still passes (R9)
    c0 = n_cmd; g0 = n_gpio;
    send_frame(16'hE00A, 256);
    repeat (4) @(negedge clk);
    chk(n_cmd == c0, "R5", "cmd for other id", 32'(n_cmd - c0), 0);
    chk(n_gpio - g0 == 1, "R9", "gpio ignores id", 32'(n_gpio - g0), 1);

    // R8: frame-valid clear blocks everything
    c0 = n_cmd; g0 = n_gpio; d0 = n_dac;
    dac_pair_sel = 2'd0;
    send_frame(16'h7FF8, 256);
    repeat (4) @(negedge clk);
    chk((n_cmd - c0) + (n_gpio - g0) + (n_dac - d0) == 0, "R8", "strobes on invalid frame",
        32'((n_cmd - c0) + (n_gpio - g0) + (n_dac - d0)), 0);

    // R1: serial data toggling outside a frame has no effect
    t0 = n_tag; c0 = n_cmd; d0 = n_dac;
    for (int i = 0; i < 300; i++) begin @(negedge clk); sdata_i = ~sdata_i; end
    @(negedge clk); sdata_i = 1'b0;
    chk(n_tag == t0 && n_cmd == c0 && n_dac == d0, "R1", "idle data", 32'(n_tag - t0), 0);

    // R10: sync rise mid-frame, then a full frame
    t0 = n_tag; c0 = n_cmd; e0 = n_err;
    send_frame(16'hE008, 40);
    send_frame(16'hE008, 256);
    repeat (4) @(negedge clk);
    chk(n_err - e0 == 1, "R10", "error pulses", 32'(n_err - e0), 1);
    chk(n_cmd - c0 == 1, "R10", "cmd from full frame only", 32'(n_cmd - c0), 1);
    chk(n_tag - t0 == 2, "R10", "tags", 32'(n_tag - t0), 2);
    chk(tag_cyc - start_cyc == 16, "R1", "restart timing", 32'(tag_cyc - start_cyc), 16);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule